// File: doc/BRIEF.md
# Four-Pin Bidirectional Port with Sleep Wake-Up

This block is the general-purpose pin port of a small processor core. It keeps one output latch per pin and a direction register that software can only write. Reads of the port return the levels sampled on the pads, never the latch contents. Two global active-low option bits enable the weak pull-ups and the wake-up on change for a fixed subset of pins. A pin that is driving an output never gets either function. Pin 3 can only be an input. Pin 2 can be handed to an external timer clock, which turns off its output driver whatever the direction bit says.

While the core sleeps, the port compares each wake-capable input pin with the value captured at the most recent port read. Any difference raises a wake request. The block remembers that a wake request happened. The reset that follows a wake therefore loads the cause flag with 1, and any other reset loads it with 0.

Top module: `gpio_wake_port`

## Requirements
- R1: `rd_data[3:0]` shows the levels on `pin_i` one clock after they are applied, whatever the latch and direction settings are. `rd_data[7:4]` is always 0.
- R2: Pin 3 (`out_en[3]`) never drives, for any value of the direction register.
- R3: A direction write loads `wr_data` into the direction register. A bit of 1 means high impedance and a bit of 0 means the pin drives its latch. `out_en` reflects the write two clocks after the write strobe is sampled.
- R4: A reset sets every direction bit to 1 and clears the output latches, so `out_en`, `pull_en`, `out_val` and `wake_req` are all 0 after reset.
- R5: `out_val` changes only on a port write and holds its value otherwise. A port read returns the pin level even where it differs from the latch.
- R6: `pull_en` for pins 0, 1 and 3 is 1 only when `pullup_n` is 0 and the pin is not driving. `pull_en[2]` is always 0.
- R7: While `tmr_clk_sel` is 1, `out_en[2]` is 0 even when direction bit 2 is 0.
- R8: `wake_req` rises two clocks after an enabled pin (0, 1 or 3, not driving, `wake_n` = 0) differs from the read snapshot, provided `sleep` is 1. Pin 2, a driving pin, `wake_n` = 1 and `sleep` = 0 each prevent it.
- R9: A reset that follows a wake request sets `wake_cause` to 1. Any other reset clears it. Between resets `wake_cause` holds its value.
- R10: A port read (`port_rd` = 1) loads the snapshot with the current sampled pins. After that read, `wake_req` falls within two clocks if the pins no longer differ.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | 4 | Levels present on the pads |
| port_wr | input | 1 | Load `wr_data` into the output latches |
| dir_wr | input | 1 | Load `wr_data` into the direction register |
| wr_data | input | 4 | Write data, low bits of the written word |
| port_rd | input | 1 | Port read; captures the wake snapshot |
| rd_data | output | 8 | Sampled pin levels, upper bits zero |
| tmr_clk_sel | input | 1 | Pin 2 handed to timer clock input |
| pullup_n | input | 1 | Global pull-up enable, active low |
| wake_n | input | 1 | Global wake-on-change enable, active low |
| sleep | input | 1 | Core is sleeping |
| out_val | output | 4 | Output latch values |
| out_en | output | 4 | Output driver enables |
| pull_en | output | 4 | Weak pull-up enables |
| wake_req | output | 1 | Wake request during sleep |
| wake_cause | output | 1 | Last reset was caused by a wake |

## Verification
Port reads are tried with pin patterns that disagree with the latched output values. A read that shows the latch instead of the pad is therefore caught. The wake path gets a mismatch on pin 2 alone, a mismatch with the global enable off, one on a driving pin, one while awake, and finally a valid one. Each masking term is thus shown to matter separately. The cause flag is checked across a reset that follows a wake and across a plain reset. This separates a flag that is captured at reset from one that simply sticks.

// File: rtl/gpio_wake_pkg.sv
package gpio_wake_pkg;
  localparam int unsigned READ_W = 8;

  // one-hot mask of a single pin index within a port of n pins
  function automatic logic [31:0] pin_bit(input int unsigned idx);
    logic [31:0] m;
    m = '0;
    m[idx] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/gpio_dir_ctl.sv
module gpio_dir_ctl #(
  parameter int unsigned         NUM_PINS    = 4,
  parameter int unsigned         IN_ONLY_PIN = 3,
  parameter int unsigned         TMR_PIN     = 2,
  parameter logic [NUM_PINS-1:0] SHARED_MASK = 4'b1011
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                dir_wr,
  input  logic [NUM_PINS-1:0] dir_data,
  input  logic                tmr_clk_sel,
  input  logic                pullup_n,
  input  logic                wake_n,
  output logic [NUM_PINS-1:0] oe_o,
  output logic [NUM_PINS-1:0] pu_o,
  output logic [NUM_PINS-1:0] wake_en_o
);
  logic [NUM_PINS-1:0] dir_q;
  logic [NUM_PINS-1:0] dir_eff;
  logic [NUM_PINS-1:0] oe_next;
  logic [NUM_PINS-1:0] pu_next;

  always_ff @(posedge clk) begin
    if (rst)         dir_q <= '1;
    else if (dir_wr) dir_q <= dir_data;
  end

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    if (i == IN_ONLY_PIN) begin : g_in_only
      assign dir_eff[i] = 1'b1;
      assign oe_next[i] = 1'b0;
    end else if (i == TMR_PIN) begin : g_tmr
      assign dir_eff[i] = dir_q[i];
      assign oe_next[i] = ~dir_q[i] & ~tmr_clk_sel;
    end else begin : g_plain
      assign dir_eff[i] = dir_q[i];
      assign oe_next[i] = ~dir_q[i];
    end
    assign pu_next[i]   = SHARED_MASK[i] & dir_eff[i] & ~pullup_n;
    assign wake_en_o[i] = SHARED_MASK[i] & dir_eff[i] & ~wake_n;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      oe_o <= '0;
      pu_o <= '0;
    end else begin
      oe_o <= oe_next;
      pu_o <= pu_next;
    end
  end

  // R2: the input-only pin never drives
  p_in_only_r2: assert property (@(posedge clk) disable iff (rst)
    !oe_o[IN_ONLY_PIN]);

  // R7: timer clock selection takes pin 2 off the driver
  p_tmr_override_r7: assert property (@(posedge clk) disable iff (rst)
    $past(tmr_clk_sel) |-> !oe_o[TMR_PIN]);
endmodule

// File: rtl/gpio_sampler.sv
module gpio_sampler #(
  parameter int unsigned NUM_PINS = 4,
  parameter int unsigned READ_W   = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic                rd_i,
  output logic [NUM_PINS-1:0] smp_o,
  output logic [NUM_PINS-1:0] snap_o,
  output logic [READ_W-1:0]   rd_data_o
);
  localparam int unsigned PAD_W = READ_W - NUM_PINS;

  logic [NUM_PINS-1:0] smp_q  = '0;
  logic [NUM_PINS-1:0] snap_q = '0;

  always_ff @(posedge clk) smp_q <= pin_i;

  always_ff @(posedge clk) begin
    if (rst || rd_i) snap_q <= smp_q;
  end

  assign smp_o     = smp_q;
  assign snap_o    = snap_q;
  assign rd_data_o = {{PAD_W{1'b0}}, smp_q};

  // R1: reads follow the pads by one clock
  p_rd_track_r1: assert property (@(posedge clk) disable iff (rst)
    rd_data_o[NUM_PINS-1:0] == $past(pin_i));
endmodule

// File: rtl/gpio_wake_ctl.sv
module gpio_wake_ctl #(
  parameter int unsigned NUM_PINS = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sleep,
  input  logic [NUM_PINS-1:0] smp_i,
  input  logic [NUM_PINS-1:0] snap_i,
  input  logic [NUM_PINS-1:0] wake_en_i,
  output logic                wake_req_o,
  output logic                cause_o
);
  logic hit;
  logic wake_q  = 1'b0;
  logic pend_q  = 1'b0;
  logic cause_q = 1'b0;

  assign hit = sleep & (|((smp_i ^ snap_i) & wake_en_i));

  always_ff @(posedge clk) begin
    if (rst) wake_q <= 1'b0;
    else     wake_q <= hit;
  end

  // pending flag survives the reset that the wake causes
  always_ff @(posedge clk) begin
    if (hit && !rst)         pend_q <= 1'b1;
    else if (!rst && !sleep) pend_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) cause_q <= pend_q;
  end

  assign wake_req_o = wake_q;
  assign cause_o    = cause_q;

  // R8: no wake request while awake
  p_wake_needs_sleep_r8: assert property (@(posedge clk) disable iff (rst)
    wake_req_o |-> $past(sleep));

  // R9: cause flag only moves on reset
  p_cause_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $stable(cause_o));
endmodule

// File: rtl/gpio_wake_port.sv
module gpio_wake_port #(
  parameter int unsigned         NUM_PINS    = 4,
  parameter int unsigned         READ_W      = gpio_wake_pkg::READ_W,
  parameter int unsigned         IN_ONLY_PIN = 3,
  parameter int unsigned         TMR_PIN     = 2,
  parameter logic [NUM_PINS-1:0] SHARED_MASK = 4'b1011
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic                port_wr,
  input  logic                dir_wr,
  input  logic [NUM_PINS-1:0] wr_data,
  input  logic                port_rd,
  output logic [READ_W-1:0]   rd_data,
  input  logic                tmr_clk_sel,
  input  logic                pullup_n,
  input  logic                wake_n,
  input  logic                sleep,
  output logic [NUM_PINS-1:0] out_val,
  output logic [NUM_PINS-1:0] out_en,
  output logic [NUM_PINS-1:0] pull_en,
  output logic                wake_req,
  output logic                wake_cause
);
  localparam logic [31:0] IN_ONLY_BIT = gpio_wake_pkg::pin_bit(IN_ONLY_PIN);

  logic [NUM_PINS-1:0] lat_q;
  logic [NUM_PINS-1:0] smp;
  logic [NUM_PINS-1:0] snap;
  logic [NUM_PINS-1:0] wake_en;

  always_ff @(posedge clk) begin
    if (rst)          lat_q <= '0;
    else if (port_wr) lat_q <= wr_data;
  end
  assign out_val = lat_q;

  gpio_dir_ctl #(
    .NUM_PINS(NUM_PINS), .IN_ONLY_PIN(IN_ONLY_PIN),
    .TMR_PIN(TMR_PIN), .SHARED_MASK(SHARED_MASK)
  ) u_dir (
    .clk(clk), .rst(rst), .dir_wr(dir_wr), .dir_data(wr_data),
    .tmr_clk_sel(tmr_clk_sel), .pullup_n(pullup_n), .wake_n(wake_n),
    .oe_o(out_en), .pu_o(pull_en), .wake_en_o(wake_en)
  );

  gpio_sampler #(.NUM_PINS(NUM_PINS), .READ_W(READ_W)) u_smp (
    .clk(clk), .rst(rst), .pin_i(pin_i), .rd_i(port_rd),
    .smp_o(smp), .snap_o(snap), .rd_data_o(rd_data)
  );

  gpio_wake_ctl #(.NUM_PINS(NUM_PINS)) u_wake (
    .clk(clk), .rst(rst), .sleep(sleep), .smp_i(smp), .snap_i(snap),
    .wake_en_i(wake_en), .wake_req_o(wake_req), .cause_o(wake_cause)
  );

  // R6: pull-up never on a driving pin
  p_pull_vs_drive_r6: assert property (@(posedge clk) disable iff (rst)
    (pull_en & out_en) == '0);

  // R5: latch holds without a port write
  p_latch_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !$past(port_wr) |-> $stable(out_val));

  // R1: unimplemented read bits stay zero
  p_rd_upper_r1: assert property (@(posedge clk) disable iff (rst)
    rd_data[READ_W-1:NUM_PINS] == '0);

  // R2: the input-only pin is never enabled
  p_in_only_top_r2: assert property (@(posedge clk) disable iff (rst)
    (out_en & IN_ONLY_BIT[NUM_PINS-1:0]) == '0);
endmodule

// File: tb/gpio_wake_port_test.sv
`timescale 1ns/1ps
module gpio_wake_port_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] pin_i = 4'b0000;
  logic       port_wr = 1'b0, dir_wr = 1'b0, port_rd = 1'b0;
  logic [3:0] wr_data = 4'b0000;
  logic       tmr_clk_sel = 1'b0, pullup_n = 1'b1, wake_n = 1'b1, sleep = 1'b0;
  logic [7:0] rd_data;
  logic [3:0] out_val, out_en, pull_en;
  logic       wake_req, wake_cause;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  gpio_wake_port uut (
    .clk(clk), .rst(rst), .pin_i(pin_i), .port_wr(port_wr), .dir_wr(dir_wr),
    .wr_data(wr_data), .port_rd(port_rd), .rd_data(rd_data),
    .tmr_clk_sel(tmr_clk_sel), .pullup_n(pullup_n), .wake_n(wake_n),
    .sleep(sleep), .out_val(out_val), .out_en(out_en), .pull_en(pull_en),
    .wake_req(wake_req), .wake_cause(wake_cause)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic write_dir(input logic [3:0] d);
    wr_data = d; dir_wr = 1'b1; step(1); dir_wr = 1'b0; step(2);
  endtask

  task automatic write_port(input logic [3:0] d);
    wr_data = d; port_wr = 1'b1; step(1); port_wr = 1'b0; step(2);
  endtask

  task automatic read_port();
    port_rd = 1'b1; step(1); port_rd = 1'b0;
  endtask

  task automatic t_reset();
    step(3); rst = 1'b0; step(1);
    check("R4 out_en",   {4'h0, out_en},   8'h00);
    check("R4 pull_en",  {4'h0, pull_en},  8'h00);
    check("R4 out_val",  {4'h0, out_val},  8'h00);
    check("R4 wake_req", {7'h0, wake_req}, 8'h00);
    check("R9 cause after power-up", {7'h0, wake_cause}, 8'h00);
  endtask

  task automatic t_read_pins();
    pin_i = 4'b1010; step(2);
    check("R1 read 1010", rd_data, 8'h0A);
    pin_i = 4'b0101; step(2);
    check("R1 read 0101", rd_data, 8'h05);
  endtask

  task automatic t_direction();
    write_dir(4'b0000);
    check("R2 R3 all drive", {4'h0, out_en}, 8'h07);
    write_dir(4'b1010);
    check("R3 dir 1010", {4'h0, out_en}, 8'h05);
    tmr_clk_sel = 1'b1; step(2);
    check("R7 timer select", {4'h0, out_en}, 8'h01);
    tmr_clk_sel = 1'b0; step(2);
    check("R7 timer released", {4'h0, out_en}, 8'h05);
  endtask

  task automatic t_latch();
    write_port(4'b1111);
    check("R5 latch written", {4'h0, out_val}, 8'h0F);
    pin_i = 4'b0000; step(2);
    check("R5 read shows pins", rd_data, 8'h00);
    wr_data = 4'b0011; step(3);
    check("R5 latch holds", {4'h0, out_val}, 8'h0F);
  endtask

  task automatic t_pullup();
    write_dir(4'b1111);
    pullup_n = 1'b0; step(2);
    check("R6 all inputs", {4'h0, pull_en}, 8'h0B);
    write_dir(4'b1110);
    check("R6 pin0 driving", {4'h0, pull_en}, 8'h0A);
    pullup_n = 1'b1; step(2);
    check("R6 disabled", {4'h0, pull_en}, 8'h00);
  endtask

  task automatic t_wake();
    write_dir(4'b1111);
    wake_n = 1'b0; pin_i = 4'b0000; step(2); read_port(); step(1);
    pin_i = 4'b0001; step(3);
    check("R8 awake no wake", {7'h0, wake_req}, 8'h00);
    pin_i = 4'b0100; sleep = 1'b1; step(3);
    check("R8 pin2 ignored", {7'h0, wake_req}, 8'h00);
    wake_n = 1'b1; pin_i = 4'b0001; step(3);
    check("R8 global disable", {7'h0, wake_req}, 8'h00);
    wake_n = 1'b0; write_dir(4'b1110); step(1);
    check("R8 driving pin ignored", {7'h0, wake_req}, 8'h00);
    write_dir(4'b1111); step(1);
    check("R8 wake raised", {7'h0, wake_req}, 8'h01);
    read_port(); step(1);
    check("R10 snapshot cleared wake", {7'h0, wake_req}, 8'h00);
    pin_i = 4'b1001; step(2);
    check("R8 pin3 wake", {7'h0, wake_req}, 8'h01);
    sleep = 1'b0; rst = 1'b1; step(2);
    check("R9 cause after wake reset", {7'h0, wake_cause}, 8'h01);
    rst = 1'b0; step(3);
    check("R9 cause holds", {7'h0, wake_cause}, 8'h01);
    rst = 1'b1; step(2);
    check("R9 cause cleared", {7'h0, wake_cause}, 8'h00);
    rst = 1'b0; step(1);
  endtask

  initial begin
    t_reset();
    t_read_pins();
    t_direction();
    t_latch();
    t_pullup();
    t_wake();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1600000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule